// File: doc/BRIEF.md
# Streaming YUV to RGB Colour Converter

This block turns a stream of 8-bit Y, U and V samples into 8-bit red, green and blue samples, one pixel per clock. Seven programmable values shape the conversion: five signed fixed-point coefficients, a signed luma offset and a signed chroma offset. Each incoming component first has its offset added, and the results are then multiplied. Red, green and blue all share one luma coefficient. Red adds a single V term, blue adds a single U term, and green adds one U term and one V term. Each channel sum is rounded back to an integer and limited to the 0 to 255 range.

Pixels travel with a valid/ready handshake through a fixed three-stage pipeline. When the consumer withdraws ready, the whole pipeline holds still. Software loads the seven values through three 32-bit configuration words. A pixel always uses the values that were in place on the clock edge that accepted it, so the configuration can be changed while pixels are still in flight.

Top module: `yuv2rgb_pipe`

## Requirements
- R1: After reset `out_valid` is 0. The luma coefficient resets to 1.0 (0x100), and all other coefficients and both offsets reset to 0, so every output channel equals the input Y.
- R2: Configuration word 0 (`cfg_sel`=0) carries the luma coefficient in bits 28:18, the chroma offset in bits 17:9 and the luma offset in bits 8:0. The offsets are 9-bit two's complement integers and are added to the raw Y (luma offset) and to the raw U and V (chroma offset) before any multiply.
- R3: Red = K0·(Y+Yoff) + K1·(V+Coff). Word 1 (`cfg_sel`=1) holds K1 in bits 26:16 and K4 in bits 10:0. Coefficients are 11-bit two's complement with 8 fraction bits.
- R4: Green = K0·(Y+Yoff) + K3·(U+Coff) + K2·(V+Coff). Word 2 (`cfg_sel`=2) holds K2 in bits 26:16 and K3 in bits 10:0.
- R5: Blue = K0·(Y+Yoff) + K4·(U+Coff).
- R6: Each channel sum is rounded to the nearest integer by adding 128 and then shifting right arithmetically by 8 bits. Exact halves round upward.
- R7: A rounded result below 0 gives 0, and a rounded result above 255 gives 255.
- R8: With `out_ready` held high, a pixel accepted on a clock edge appears on the outputs after the third clock edge that follows, counting the accepting edge as the first.
- R9: `in_ready` follows `out_ready`. While `out_valid` is high and `out_ready` is low, the outputs do not change. No pixel is lost or duplicated.
- R10: A pixel uses the configuration that was in place before the edge that accepted it. A write on that same edge, or on any later edge, does not affect that pixel.
- R11: A write with `cfg_sel`=3 changes no configuration value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Selects which configuration word is written |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | Blue-difference chroma sample |
| in_v | input | 8 | Red-difference chroma sample |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer can take a pixel |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |

## Verification
The bench builds the block with its default parameters: 8-bit samples, 11-bit coefficients with 8 fraction bits, and 9-bit offsets. Coefficients of about +4.0 and exactly −1.0 can therefore be written, which drives each channel into both saturation limits with ordinary pixel values. A coefficient of 0.5 puts sums exactly on the half-way point, which exercises the rounding. A behavioural model computes the expected colour at each acceptance and queues it. The bench then compares every delivered pixel while `out_ready` toggles at random and configuration writes land on the same edge as pixels in flight.

// File: rtl/yuv2rgb_pkg.sv
package yuv2rgb_pkg;

  // Output channel positions inside the packed pixel vector
  localparam int CH_RED   = 0;
  localparam int CH_GREEN = 1;
  localparam int CH_BLUE  = 2;
  localparam int NUM_CH   = 3;

  // Number of coefficient slots (K0 luma, K1..K4 chroma)
  localparam int NUM_COEF = 5;

  // Configuration word selectors
  localparam logic [1:0] SEL_LUMA     = 2'd0;
  localparam logic [1:0] SEL_RED_BLUE = 2'd1;
  localparam logic [1:0] SEL_GREEN    = 2'd2;

  // Low bit of the upper coefficient field in words 1 and 2
  localparam int HI_FIELD_LSB = 16;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/yuv2rgb_cfg.sv
module yuv2rgb_cfg
  import yuv2rgb_pkg::*;
#(
  parameter int COEF_W = 11,
  parameter int OFF_W  = 9,
  parameter int FRAC_W = 8,
  parameter int CFG_W  = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [1:0]                         sel,
  input  logic [CFG_W-1:0]                   wdata,
  output logic [NUM_COEF-1:0][COEF_W-1:0]    coef,
  output logic [OFF_W-1:0]                   y_off,
  output logic [OFF_W-1:0]                   c_off
);

  localparam int LUMA_LSB = 2 * OFF_W;
  localparam int USED_TOP = max_i(LUMA_LSB + COEF_W, HI_FIELD_LSB + COEF_W);
  localparam logic [NUM_COEF-1:0][COEF_W-1:0] COEF_RST =
    (NUM_COEF*COEF_W)'(1 << FRAC_W);

  logic [NUM_COEF-1:0][COEF_W-1:0] coef_d, coef_q;
  logic [OFF_W-1:0]                y_off_d, y_off_q;
  logic [OFF_W-1:0]                c_off_d, c_off_q;
  logic                            load_en;

  logic unused_wdata;
  assign unused_wdata = ^wdata[CFG_W-1:USED_TOP];

  assign load_en = we;

  // Next-state decode of the selected word
  always_comb begin
    coef_d  = coef_q;
    y_off_d = y_off_q;
    c_off_d = c_off_q;
    case (sel)
      SEL_LUMA: begin
        coef_d[0] = wdata[LUMA_LSB +: COEF_W];
        c_off_d   = wdata[OFF_W +: OFF_W];
        y_off_d   = wdata[0 +: OFF_W];
      end
      SEL_RED_BLUE: begin
        coef_d[1] = wdata[HI_FIELD_LSB +: COEF_W];
        coef_d[4] = wdata[0 +: COEF_W];
      end
      SEL_GREEN: begin
        coef_d[2] = wdata[HI_FIELD_LSB +: COEF_W];
        coef_d[3] = wdata[0 +: COEF_W];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q  <= COEF_RST;
      y_off_q <= '0;
      c_off_q <= '0;
    end else if (load_en) begin
      coef_q  <= coef_d;
      y_off_q <= y_off_d;
      c_off_q <= c_off_d;
    end
  end

  assign coef  = coef_q;
  assign y_off = y_off_q;
  assign c_off = c_off_q;

  // R11: the unused selector leaves every stored value alone
  p_sel3_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 2'd3) |=> ($stable(coef) && $stable(y_off) && $stable(c_off)));

endmodule

// File: rtl/yuv2rgb_front.sv
module yuv2rgb_front
  import yuv2rgb_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 11,
  parameter int OFF_W  = 9,
  parameter int ADJ_W  = 10
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               adv,
  input  logic [PIX_W-1:0]                   in_y,
  input  logic [PIX_W-1:0]                   in_u,
  input  logic [PIX_W-1:0]                   in_v,
  input  logic [NUM_COEF-1:0][COEF_W-1:0]    coef,
  input  logic [OFF_W-1:0]                   y_off,
  input  logic [OFF_W-1:0]                   c_off,
  output logic signed [ADJ_W-1:0]            y_adj,
  output logic signed [ADJ_W-1:0]            u_adj,
  output logic signed [ADJ_W-1:0]            v_adj,
  output logic [NUM_COEF-1:0][COEF_W-1:0]    coef_s1
);

  logic signed [ADJ_W-1:0]         y_adj_d, u_adj_d, v_adj_d;
  logic signed [ADJ_W-1:0]         y_adj_q, u_adj_q, v_adj_q;
  logic signed [ADJ_W-1:0]         y_off_x, c_off_x;
  logic [NUM_COEF-1:0][COEF_W-1:0] coef_q;

  // Stage 1: offset-adjust raw components, widened to keep the full range
  always_comb begin
    y_off_x = ADJ_W'($signed(y_off));
    c_off_x = ADJ_W'($signed(c_off));
    y_adj_d = ADJ_W'($signed({1'b0, in_y})) + y_off_x;
    u_adj_d = ADJ_W'($signed({1'b0, in_u})) + c_off_x;
    v_adj_d = ADJ_W'($signed({1'b0, in_v})) + c_off_x;
  end

  // Coefficients travel with the pixel so later writes do not reach it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_adj_q <= '0;
      u_adj_q <= '0;
      v_adj_q <= '0;
      coef_q  <= '0;
    end else if (adv) begin
      y_adj_q <= y_adj_d;
      u_adj_q <= u_adj_d;
      v_adj_q <= v_adj_d;
      coef_q  <= coef;
    end
  end

  assign y_adj   = y_adj_q;
  assign u_adj   = u_adj_q;
  assign v_adj   = v_adj_q;
  assign coef_s1 = coef_q;

endmodule

// File: rtl/yuv2rgb_chan.sv
module yuv2rgb_chan #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 11,
  parameter int ADJ_W  = 10,
  parameter int FRAC_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  input  logic signed [ADJ_W-1:0]    y_adj,
  input  logic signed [ADJ_W-1:0]    u_adj,
  input  logic signed [ADJ_W-1:0]    v_adj,
  input  logic signed [COEF_W-1:0]   k_y,
  input  logic signed [COEF_W-1:0]   k_u,
  input  logic signed [COEF_W-1:0]   k_v,
  output logic [PIX_W-1:0]           pix
);

  localparam int PROD_W = ADJ_W + COEF_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam logic signed [SUM_W-1:0] HALF_LSB = SUM_W'(1) << (FRAC_W - 1);
  localparam logic signed [SUM_W-1:0] PIX_MAX  = SUM_W'((1 << PIX_W) - 1);

  logic signed [PROD_W-1:0] py_d, pu_d, pv_d;
  logic signed [PROD_W-1:0] py_q, pu_q, pv_q;
  logic signed [SUM_W-1:0]  acc, rnd;
  logic [PIX_W-1:0]         pix_d, pix_q;

  // Stage 2: three signed products
  always_comb begin
    py_d = PROD_W'(y_adj) * PROD_W'(k_y);
    pu_d = PROD_W'(u_adj) * PROD_W'(k_u);
    pv_d = PROD_W'(v_adj) * PROD_W'(k_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      py_q <= '0;
      pu_q <= '0;
      pv_q <= '0;
    end else if (adv) begin
      py_q <= py_d;
      pu_q <= pu_d;
      pv_q <= pv_d;
    end
  end

  // Stage 3: sum, round half up, saturate
  always_comb begin
    acc = SUM_W'(py_q) + SUM_W'(pu_q) + SUM_W'(pv_q) + HALF_LSB;
    rnd = acc >>> FRAC_W;
    if (rnd[SUM_W-1])
      pix_d = '0;
    else if (rnd > PIX_MAX)
      pix_d = '1;
    else
      pix_d = rnd[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pix_q <= '0;
    else if (adv)
      pix_q <= pix_d;
  end

  assign pix = pix_q;

  // R7: negative rounded sums land on zero
  p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && rnd[SUM_W-1]) |=> (pix == '0));

  // R7: rounded sums above the pixel range land on full scale
  p_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !rnd[SUM_W-1] && rnd > PIX_MAX) |=> (pix == {PIX_W{1'b1}}));

endmodule

// File: rtl/yuv2rgb_pipe.sv
module yuv2rgb_pipe
  import yuv2rgb_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 11,
  parameter int OFF_W  = 9,
  parameter int FRAC_W = 8,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_y,
  input  logic [PIX_W-1:0]  in_u,
  input  logic [PIX_W-1:0]  in_v,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);

  localparam int ADJ_W   = max_i(PIX_W + 1, OFF_W) + 1;
  localparam int N_STAGE = 3;

  logic                            rst_meta_q, rst_ok_q;
  logic                            adv, accept;
  logic [N_STAGE-1:0]              vld_d, vld_q;
  logic [NUM_COEF-1:0][COEF_W-1:0] coef, coef_s1;
  logic [OFF_W-1:0]                y_off, c_off;
  logic signed [ADJ_W-1:0]         y_adj, u_adj, v_adj;
  logic [NUM_CH-1:0][PIX_W-1:0]    pix;

  // Reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ok_q   <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ok_q   <= rst_meta_q;
    end
  end

  // Whole-pipeline stall driven by the consumer
  assign adv      = out_ready;
  assign in_ready = out_ready & rst_ok_q;
  assign accept   = in_valid & in_ready;

  always_comb vld_d = {vld_q[N_STAGE-2:0], accept};

  always_ff @(posedge clk or negedge rst_ok_q) begin
    if (!rst_ok_q)
      vld_q <= '0;
    else if (adv)
      vld_q <= vld_d;
  end

  assign out_valid = vld_q[N_STAGE-1];

  yuv2rgb_cfg #(
    .COEF_W (COEF_W),
    .OFF_W  (OFF_W),
    .FRAC_W (FRAC_W),
    .CFG_W  (CFG_W)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_ok_q),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .coef  (coef),
    .y_off (y_off),
    .c_off (c_off)
  );

  yuv2rgb_front #(
    .PIX_W  (PIX_W),
    .COEF_W (COEF_W),
    .OFF_W  (OFF_W),
    .ADJ_W  (ADJ_W)
  ) u_front (
    .clk     (clk),
    .rst_n   (rst_ok_q),
    .adv     (adv),
    .in_y    (in_y),
    .in_u    (in_u),
    .in_v    (in_v),
    .coef    (coef),
    .y_off   (y_off),
    .c_off   (c_off),
    .y_adj   (y_adj),
    .u_adj   (u_adj),
    .v_adj   (v_adj),
    .coef_s1 (coef_s1)
  );

  // Per-channel chroma coefficient routing: red V only, blue U only, green both
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic signed [COEF_W-1:0] k_u, k_v;

    if (g == CH_RED) begin : g_red
      assign k_u = '0;
      assign k_v = coef_s1[1];
    end else if (g == CH_GREEN) begin : g_green
      assign k_u = coef_s1[3];
      assign k_v = coef_s1[2];
    end else begin : g_blue
      assign k_u = coef_s1[4];
      assign k_v = '0;
    end

    yuv2rgb_chan #(
      .PIX_W  (PIX_W),
      .COEF_W (COEF_W),
      .ADJ_W  (ADJ_W),
      .FRAC_W (FRAC_W)
    ) u_chan (
      .clk   (clk),
      .rst_n (rst_ok_q),
      .adv   (adv),
      .y_adj (y_adj),
      .u_adj (u_adj),
      .v_adj (v_adj),
      .k_y   (coef_s1[0]),
      .k_u   (k_u),
      .k_v   (k_v),
      .pix   (pix[g])
    );
  end

  assign out_r = pix[CH_RED];
  assign out_g = pix[CH_GREEN];
  assign out_b = pix[CH_BLUE];

  // Settling counter so latency checks never look before reset release
  logic [1:0] settle_q;
  always_ff @(posedge clk or negedge rst_ok_q) begin
    if (!rst_ok_q)
      settle_q <= '0;
    else if (settle_q != 2'd3)
      settle_q <= settle_q + 2'd1;
  end

  // R8: three advancing edges carry an accepted pixel to the output
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_ok_q)
    (settle_q == 2'd3 && $past(adv, 1) && $past(adv, 2) && $past(adv, 3))
      |-> (out_valid == $past(accept, 3)));

  // R9: a stalled output keeps its pixel unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_ok_q)
    (out_valid && !out_ready)
      |=> (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));

endmodule

// File: tb/yuv2rgb_pipe_test.sv
module yuv2rgb_pipe_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_y, in_u, in_v;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_r, out_g, out_b;

  always #4 clk = ~clk;

  yuv2rgb_pipe uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_y      (in_y),
    .in_u      (in_u),
    .in_v      (in_v),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b)
  );

  int    checks   = 0;
  int    failures = 0;
  string tag      = "R1";
  bit    stall_mode = 1'b0;

  typedef struct {
    int    r;
    int    g;
    int    b;
    string t;
  } pix_t;

  pix_t exp_q[$];

  // Model configuration (R1 reset values)
  int m_k[5];
  int m_yo;
  int m_co;

  function automatic int sx(input int v, input int bits);
    int m;
    m = v & ((1 << bits) - 1);
    return (m >= (1 << (bits - 1))) ? m - (1 << bits) : m;
  endfunction

  function automatic int finish_ch(input int s);
    int r;
    r = (s + 128) >>> 8;
    if (r < 0)   r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic fail_msg(input string req, input string what, input int act, input int expv);
    failures++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
  endtask

  // Behavioural model: sample bench-driven inputs at the edge
  always @(posedge clk) begin
    if (rst_n) begin
      if (in_valid && in_ready) begin
        pix_t p;
        int ya, ua, va;
        ya  = int'(in_y) + m_yo;
        ua  = int'(in_u) + m_co;
        va  = int'(in_v) + m_co;
        p.r = finish_ch(m_k[0]*ya + m_k[1]*va);
        p.g = finish_ch(m_k[0]*ya + m_k[3]*ua + m_k[2]*va);
        p.b = finish_ch(m_k[0]*ya + m_k[4]*ua);
        p.t = tag;
        exp_q.push_back(p);
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin
            m_k[0] = sx(int'(cfg_wdata >> 18), 11);
            m_co   = sx(int'(cfg_wdata >> 9), 9);
            m_yo   = sx(int'(cfg_wdata), 9);
          end
          2'd1: begin
            m_k[1] = sx(int'(cfg_wdata >> 16), 11);
            m_k[4] = sx(int'(cfg_wdata), 11);
          end
          2'd2: begin
            m_k[2] = sx(int'(cfg_wdata >> 16), 11);
            m_k[3] = sx(int'(cfg_wdata), 11);
          end
          default: ;
        endcase
      end
    end
  end

  // Random back-pressure, driven at the falling edge
  always @(negedge clk) begin
    if (stall_mode) out_ready <= ($urandom % 3) != 0;
    else            out_ready <= 1'b1;
  end

  // Scoreboard and stall-hold check, away from both edges
  bit         hold_prev = 1'b0;
  logic [7:0] h_r, h_g, h_b;

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (hold_prev) begin
        checks++;
        if (!out_valid)
          fail_msg("R9", "valid dropped during stall", 0, 1);
        else if (out_r != h_r || out_g != h_g || out_b != h_b)
          fail_msg("R9", "held pixel changed (rgb packed)",
                   int'({out_r, out_g, out_b}), int'({h_r, h_g, h_b}));
      end
      hold_prev = out_valid && !out_ready;
      h_r = out_r; h_g = out_g; h_b = out_b;

      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fail_msg("R9", "unexpected extra pixel", 1, 0);
        end else begin
          pix_t e;
          e = exp_q.pop_front();
          if (int'(out_r) != e.r) fail_msg(e.t, "red",   int'(out_r), e.r);
          if (int'(out_g) != e.g) fail_msg(e.t, "green", int'(out_g), e.g);
          if (int'(out_b) != e.b) fail_msg(e.t, "blue",  int'(out_b), e.b);
        end
      end
    end
  end

  task automatic send(input int y, input int u, input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_y = 8'(y); in_u = 8'(u); in_v = 8'(v);
    forever begin
      @(posedge clk);
      if (in_ready) break;
    end
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain(input string req);
    idle_in();
    stall_mode = 1'b0;
    repeat (10) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) fail_msg(req, "pixels left in flight", exp_q.size(), 0);
  endtask

  function automatic logic [31:0] w0(input int k0, input int co, input int yo);
    return (32'(k0 & 'h7FF) << 18) | (32'(co & 'h1FF) << 9) | 32'(yo & 'h1FF);
  endfunction

  function automatic logic [31:0] whl(input int hi, input int lo);
    return (32'(hi & 'h7FF) << 16) | 32'(lo & 'h7FF);
  endfunction

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_k[0] = 256; m_k[1] = 0; m_k[2] = 0; m_k[3] = 0; m_k[4] = 0;
    m_yo = 0; m_co = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_y = '0; in_u = '0; in_v = '0; out_ready = 1'b1;

    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) fail_msg("R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) fail_msg("R1", "out_valid after reset", int'(out_valid), 0);

    // R1: default configuration passes Y to all channels
    tag = "R1";
    send(0, 17, 200); send(255, 0, 0); send(77, 128, 128); send(128, 255, 255);
    drain("R1");

    // R8: latency of three edges
    tag = "R8";
    @(negedge clk);
    in_valid = 1'b1; in_y = 8'd42; in_u = 8'd1; in_v = 8'd2;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    checks++;
    if (out_valid !== 1'b0) fail_msg("R8", "valid after 1 edge", int'(out_valid), 0);
    @(negedge clk); #1;
    checks++;
    if (out_valid !== 1'b0) fail_msg("R8", "valid after 2 edges", int'(out_valid), 0);
    @(negedge clk); #1;
    checks++;
    if (out_valid !== 1'b1) fail_msg("R8", "valid after 3 edges", int'(out_valid), 1);
    checks++;
    if (out_r != 8'd42) fail_msg("R8", "red after 3 edges", int'(out_r), 42);
    drain("R8");

    // R3/R4/R5 with the sample matrix; 128,128,128 must give 128 grey
    tag = "R3";
    wr(2'd0, w0('h100, -128, 0));
    wr(2'd1, whl('h123, 'h208));
    wr(2'd2, whl('h76B, 'h79B));
    send(128, 128, 128);
    drain("R3");
    tag = "R4";
    for (int i = 0; i < 24; i++) send($urandom % 256, $urandom % 256, $urandom % 256);
    tag = "R5";
    send(16, 240, 16); send(235, 16, 240); send(0, 0, 0); send(255, 255, 255);
    drain("R5");

    // R2: luma offset added before multiply
    tag = "R2";
    wr(2'd0, w0('h12A, -128, -16));
    send(16, 128, 128); send(235, 128, 128); send(0, 128, 128); send(100, 90, 160);
    drain("R2");

    // R6: round half up with K0 = 0.5 and no chroma
    tag = "R6";
    wr(2'd0, w0('h080, 0, 0));
    wr(2'd1, whl(0, 0));
    wr(2'd2, whl(0, 0));
    send(1, 0, 0); send(3, 0, 0); send(255, 0, 0); send(2, 0, 0);
    drain("R6");

    // R7: saturation at both ends
    tag = "R7";
    wr(2'd0, w0('h3FF, 0, 0));
    send(200, 0, 0); send(63, 0, 0);
    wr(2'd0, w0('h700, 0, 0));
    send(50, 0, 0); send(0, 0, 0);
    wr(2'd0, w0('h100, 0, -16));
    send(0, 0, 0); send(10, 0, 0);
    drain("R7");

    // R10: writes on the accepting edge and later do not reach earlier pixels
    tag = "R10";
    wr(2'd0, w0('h100, 0, 0));
    @(negedge clk);
    in_valid = 1'b1; in_y = 8'd60; in_u = '0; in_v = '0;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = w0('h200, 0, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    in_y = 8'd60;
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = w0('h080, 0, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    send(60, 0, 0);
    drain("R10");

    // R11: selector 3 changes nothing
    tag = "R11";
    wr(2'd3, 32'hFFFF_FFFF);
    send(60, 0, 0); send(201, 10, 20);
    drain("R11");

    // R9: random back-pressure with a full matrix
    tag = "R9";
    wr(2'd0, w0('h12A, -128, -16));
    wr(2'd1, whl('h198, 'h204));
    wr(2'd2, whl(-'h0D0, -'h064));
    stall_mode = 1'b1;
    for (int i = 0; i < 60; i++) send($urandom % 256, $urandom % 256, $urandom % 256);
    drain("R9");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule